// File: doc/BRIEF.md
# SDRAM Read Command Sequencer

This block turns word-address read requests into command sequences for a single-data-rate SDRAM-style device. A request carries a flat word address. The upper bits select the row and the lower bits select the column, and both halves go out one after the other on one shared address pin group. The block remembers which row it left open. A request to that row goes straight to a column read. A request to any other row first closes the open row, then waits, then opens the new row, then waits again before the column read.

The read data comes back a fixed number of cycles after each column read. It arrives as a burst of 2, 4 or 8 words, one word per clock. The block captures each word and presents it on a result port, and it marks the final word of each burst. Every command timing value is a configuration input, and all of them must stay stable while requests are in flight.

The request port follows valid/ready rules. A request is taken on a rising edge where both `req_valid` and `req_ready` are high. `req_ready` is low from the cycle after acceptance until that request's column read has been issued. The result port has no back-pressure input, because the memory cannot be stalled once a burst starts. A consumer must therefore take one word on every cycle that `rd_valid` is high.

Top module: `sdram_rd_seq`

## Requirements
- R1: During reset and right after it, the command pins show the idle encoding (`mem_ras_n`, `mem_cas_n`, `mem_we_n` all 1), `rd_valid` is 0, `req_ready` is 1, and no row is considered open.
- R2: When no row is open, a request first issues a row-open command: `mem_ras_n`=0, `mem_cas_n`=1, `mem_we_n`=1, held for one cycle, with the request's row on `mem_addr`.
- R3: A column read is encoded as `mem_ras_n`=1, `mem_cas_n`=0, `mem_we_n`=1, with the column on `mem_addr`. It comes no sooner than `cfg_trcd` cycles after the row-open command of its row, where a value of 0 counts as 1.
- R4: The first word of a burst is the value of `mem_dq` at the rising edge `cfg_cl` cycles after the edge that sampled the column read, where a value of 0 counts as 1. Each word appears on `rd_data` with `rd_valid`=1 in the following cycle.
- R5: `cfg_bl` selects the burst length: 0 gives 2 words, 1 gives 4 words, and 2 or 3 give 8 words. The words arrive on consecutive cycles, and `rd_last` is 1 on the final word and only there.
- R6: A request to the row that is already open issues no row-open command and no close command, only a column read.
- R7: Two column reads are at least max(command rate, burst length) cycles apart, where the command rate is 2 when `cfg_rate2`=1 and 1 otherwise. A close command likewise waits until the last burst is complete. Bursts therefore never overlap, and results come back in request order.
- R8: A request to a different row while a row is open first issues a close command: `mem_ras_n`=0, `mem_cas_n`=1, `mem_we_n`=0. The row-open command follows no sooner than `cfg_trp` cycles later, where a value of 0 counts as 1.
- R9: In every cycle without a command, the pins show the idle encoding. No encoding other than idle, row-open, column read and close ever appears.
- R10: After a request is accepted, `req_ready` is 0 in the next cycle.
- R11: The row is `req_addr[ROW_W+COL_W-1:COL_W]` and the column is `req_addr[COL_W-1:0]`. Each is zero-extended onto `mem_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the memory samples on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_addr | input | ROW_W+COL_W | Word address of the burst |
| cfg_trcd | input | TW | Row-open to column-read spacing, in cycles |
| cfg_cl | input | TW | Column read to first data word, in cycles |
| cfg_trp | input | TW | Close to row-open spacing, in cycles |
| cfg_bl | input | 2 | Burst length code |
| cfg_rate2 | input | 1 | 1 selects a two-cycle command rate |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | max(ROW_W,COL_W) | Shared row/column address pins |
| mem_dq | input | DATA_W | Data from the memory |
| rd_valid | output | 1 | Returned word present |
| rd_data | output | DATA_W | Returned word |
| rd_last | output | 1 | Final word of a burst |

## Verification
The bench aims at the three row cases: a cold start with no open row, a hit on the open row, and a miss that forces a close. A design that kept stale row state would either re-open a row that is already open, or read from the wrong row, and the returned words would not match. Back-to-back hits with bursts of 8 test the spacing between column reads: if that spacing were too short, bursts would overlap, the model would flag the gap, and words would arrive out of order. Minimum timings of 1 cycle and longer latencies test the capture window. If the window were off by one, the returned words would be shifted, and `rd_last` would land on the wrong beat.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;

  // {ras_n, cas_n, we_n}
  typedef enum logic [2:0] {
    CMD_PRE  = 3'b010,
    CMD_ACT  = 3'b011,
    CMD_READ = 3'b101,
    CMD_NOP  = 3'b111
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_ACT  = 2'd2,
    ST_COL  = 2'd3
  } seq_st_e;

  function automatic logic [3:0] burst_words(input logic [1:0] code);
    case (code)
      2'b00:   return 4'd2;
      2'b01:   return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/sdram_addr_split.sv
module sdram_addr_split #(
  parameter int ROW_W = 8,
  parameter int COL_W = 8,
  localparam int ADDR_W = ROW_W + COL_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col
);
  // R11: upper half selects the row, lower half the column
  assign row = addr[ADDR_W-1 -: ROW_W];
  assign col = addr[COL_W-1:0];
endmodule

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdram_rd_pkg::*;
#(
  parameter int ROW_W = 8,
  parameter int COL_W = 8,
  parameter int TW    = 4,
  parameter int MA_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  output logic             req_ready,
  input  logic [TW-1:0]    cfg_trcd,
  input  logic [TW-1:0]    cfg_trp,
  input  logic [TW-1:0]    rd_gap,
  output logic [2:0]       cmd_o,
  output logic [MA_W-1:0]  addr_o,
  output logic             rd_issue
);
  seq_st_e          st;
  cmd_e             cmd_q;
  logic [MA_W-1:0]  addr_q;
  logic [ROW_W-1:0] row_q, open_row;
  logic [COL_W-1:0] col_q;
  logic             open_vld;
  logic [TW-1:0]    row_tmr, col_tmr;
  logic [TW-1:0]    trcd_e, trp_e, gap_e;
  logic             accept, issue_pre, issue_act, issue_rd, hit;

  assign trcd_e = (cfg_trcd == '0) ? TW'(1) : cfg_trcd;
  assign trp_e  = (cfg_trp  == '0) ? TW'(1) : cfg_trp;
  assign gap_e  = (rd_gap   == '0) ? TW'(1) : rd_gap;

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign hit       = open_vld && (req_row == open_row);
  // a close waits for the running burst; a row-open waits for tRP
  assign issue_pre = (st == ST_PRE) && (col_tmr == '0);
  assign issue_act = (st == ST_ACT) && (row_tmr == '0);
  assign issue_rd  = (st == ST_COL) && (row_tmr == '0) && (col_tmr == '0);
  assign rd_issue  = issue_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cmd_q    <= CMD_NOP;
      addr_q   <= '0;
      row_q    <= '0;
      col_q    <= '0;
      open_row <= '0;
      open_vld <= 1'b0;
      row_tmr  <= '0;
      col_tmr  <= '0;
    end else begin
      cmd_q  <= CMD_NOP;
      addr_q <= '0;

      if (issue_pre)           row_tmr <= trp_e - TW'(1);
      else if (issue_act)      row_tmr <= trcd_e - TW'(1);
      else if (row_tmr != '0)  row_tmr <= row_tmr - TW'(1);

      if (issue_rd)            col_tmr <= gap_e - TW'(1);
      else if (col_tmr != '0)  col_tmr <= col_tmr - TW'(1);

      case (st)
        ST_IDLE: if (accept) begin
          row_q <= req_row;
          col_q <= req_col;
          if (hit)           st <= ST_COL;
          else if (open_vld) st <= ST_PRE;
          else               st <= ST_ACT;
        end
        ST_PRE: if (issue_pre) begin
          cmd_q    <= CMD_PRE;
          open_vld <= 1'b0;
          st       <= ST_ACT;
        end
        ST_ACT: if (issue_act) begin
          cmd_q    <= CMD_ACT;
          addr_q   <= MA_W'(row_q);
          open_row <= row_q;
          open_vld <= 1'b1;
          st       <= ST_COL;
        end
        default: if (issue_rd) begin
          cmd_q  <= CMD_READ;
          addr_q <= MA_W'(col_q);
          st     <= ST_IDLE;
        end
      endcase
    end
  end

  assign cmd_o  = cmd_q;
  assign addr_o = addr_q;
endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture #(
  parameter int DATA_W = 16,
  parameter int TW     = 4,
  localparam int DEPTH = 1 << TW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_issue,
  input  logic [TW-1:0]     cfg_cl,
  input  logic [TW-1:0]     bl_len,
  input  logic [DATA_W-1:0] mem_dq,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_last
);
  logic [DEPTH-1:0] launch_sr;
  logic [TW-1:0]    cl_e, beats_left;
  logic             start, cap, last_now;

  assign cl_e = (cfg_cl == '0) ? TW'(1) : cfg_cl;
  // issue at cycle c -> pins at c+1 -> first word sampled CL edges later
  assign start    = launch_sr[cl_e];
  assign cap      = start || (beats_left != '0);
  assign last_now = start ? (bl_len == TW'(1)) : (beats_left == TW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      launch_sr  <= '0;
      beats_left <= '0;
      rd_valid   <= 1'b0;
      rd_last    <= 1'b0;
      rd_data    <= '0;
    end else begin
      launch_sr <= {launch_sr[DEPTH-2:0], rd_issue};
      if (start)                 beats_left <= bl_len - TW'(1);
      else if (beats_left != '0) beats_left <= beats_left - TW'(1);
      rd_valid <= cap;
      rd_last  <= cap && last_now;
      if (cap) rd_data <= mem_dq;
    end
  end
endmodule

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq
  import sdram_rd_pkg::*;
#(
  parameter int ROW_W  = 8,
  parameter int COL_W  = 8,
  parameter int DATA_W = 16,
  parameter int TW     = 4,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [TW-1:0]     cfg_trcd,
  input  logic [TW-1:0]     cfg_cl,
  input  logic [TW-1:0]     cfg_trp,
  input  logic [1:0]        cfg_bl,
  input  logic              cfg_rate2,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic [MA_W-1:0]   mem_addr,
  input  logic [DATA_W-1:0] mem_dq,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_last
);
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  logic [TW-1:0]    bl_len, rate, gap;
  logic [2:0]       cmd;
  logic             rd_issue;

  assign bl_len = TW'(burst_words(cfg_bl));
  assign rate   = cfg_rate2 ? TW'(2) : TW'(1);
  assign gap    = (bl_len > rate) ? bl_len : rate;

  sdram_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W)) u_split (
    .addr(req_addr), .row(row), .col(col)
  );

  sdram_cmd_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .TW(TW), .MA_W(MA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_row(row),
    .req_col(col), .req_ready(req_ready), .cfg_trcd(cfg_trcd),
    .cfg_trp(cfg_trp), .rd_gap(gap), .cmd_o(cmd), .addr_o(mem_addr),
    .rd_issue(rd_issue)
  );

  sdram_rd_capture #(.DATA_W(DATA_W), .TW(TW)) u_cap (
    .clk(clk), .rst_n(rst_n), .rd_issue(rd_issue), .cfg_cl(cfg_cl),
    .bl_len(bl_len), .mem_dq(mem_dq), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_last(rd_last)
  );

  assign mem_ras_n = cmd[2];
  assign mem_cas_n = cmd[1];
  assign mem_we_n  = cmd[0];
endmodule

// File: rtl/sdram_rd_seq_chk.sv
module sdram_rd_seq_chk #(
  parameter int TW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          mem_ras_n,
  input logic          mem_cas_n,
  input logic          mem_we_n,
  input logic          rd_valid,
  input logic          rd_last,
  input logic [TW-1:0] cfg_trcd,
  input logic [TW-1:0] cfg_trp
);
  logic act_cmd, rd_cmd, pre_cmd;
  assign act_cmd = !mem_ras_n &&  mem_cas_n &&  mem_we_n;
  assign rd_cmd  =  mem_ras_n && !mem_cas_n &&  mem_we_n;
  assign pre_cmd = !mem_ras_n &&  mem_cas_n && !mem_we_n;

  AST_LEGAL_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (act_cmd || rd_cmd || pre_cmd || (mem_ras_n && mem_cas_n && mem_we_n))); // R9
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R10
  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> rd_valid); // R5
  AST_BURST_ENDS_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_valid) |-> $past(rd_last)); // R5
  AST_RCD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (act_cmd && (cfg_trcd > TW'(1))) |=> !rd_cmd); // R3
  AST_TRP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_cmd && (cfg_trp > TW'(1))) |=> !act_cmd); // R8
endmodule

bind sdram_rd_seq sdram_rd_seq_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
  .rd_valid(rd_valid), .rd_last(rd_last), .cfg_trcd(cfg_trcd),
  .cfg_trp(cfg_trp)
);

// File: tb/sim_sdram_rd_seq.sv
module sim_sdram_rd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 8, COL_W = 8, DATA_W = 16, TW = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [15:0] req_addr = '0;
  logic [TW-1:0] cfg_trcd = 2, cfg_cl = 2, cfg_trp = 2;
  logic [1:0] cfg_bl = 1;
  logic cfg_rate2 = 0;
  logic mem_ras_n, mem_cas_n, mem_we_n;
  logic [7:0] mem_addr;
  logic [15:0] mem_dq = 16'hDEAD;
  logic rd_valid, rd_last;
  logic [15:0] rd_data;

  sdram_rd_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .cfg_trcd(cfg_trcd), .cfg_cl(cfg_cl),
    .cfg_trp(cfg_trp), .cfg_bl(cfg_bl), .cfg_rate2(cfg_rate2),
    .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dq(mem_dq), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_last(rd_last)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  function automatic int blen();
    case (cfg_bl) 2'd0: return 2; 2'd1: return 4; default: return 8; endcase
  endfunction
  function automatic int eff(input logic [TW-1:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction
  function automatic logic [15:0] word_of(input logic [15:0] a, input int b);
    logic [7:0] bb;
    bb = 8'(b);
    return {a[15:8] + bb, a[7:0] ^ (bb * 8'd37)};
  endfunction

  // memory model: pins seen at a negedge are sampled at edge cyc+1
  bit m_open = 0;
  logic [7:0] m_row = 0;
  int last_act = -1000, last_pre = -1000, last_rd = -1000;
  int n_act = 0, n_pre = 0, n_rd = 0;
  logic [15:0] sch_data [64];
  bit sch_v [64];
  int rd_edges[$];

  always @(negedge clk) begin : mem_model
    int e, slot;
    e = cyc + 1;
    if (rst_n) begin
      case ({mem_ras_n, mem_cas_n, mem_we_n})
        3'b111: ;
        3'b011: begin
          check(!m_open, "R8 row-open while a row is open", int'(m_open), 0);
          check(e - last_pre >= eff(cfg_trp), "R8 tRP spacing", e - last_pre, eff(cfg_trp));
          m_open = 1; m_row = mem_addr; last_act = e; n_act++;
        end
        3'b101: begin
          check(m_open, "R2 column read with no open row", int'(m_open), 1);
          check(e - last_act >= eff(cfg_trcd), "R3 tRCD spacing", e - last_act, eff(cfg_trcd));
          check(e - last_rd >= blen(), "R7 column read spacing", e - last_rd, blen());
          for (int i = 0; i < blen(); i++) begin
            slot = (e + eff(cfg_cl) + i) % 64;
            sch_v[slot] = 1;
            sch_data[slot] = word_of({m_row, mem_addr}, i);
          end
          rd_edges.push_back(e); last_rd = e; n_rd++;
        end
        3'b010: begin
          check(e - last_rd >= blen(), "R7 close before burst done", e - last_rd, blen());
          m_open = 0; last_pre = e; n_pre++;
        end
        default: check(0, "R9 illegal command encoding",
                       int'({mem_ras_n, mem_cas_n, mem_we_n}), 7);
      endcase
    end
    slot = e % 64;
    if (sch_v[slot]) begin mem_dq = sch_data[slot]; sch_v[slot] = 0; end
    else mem_dq = 16'hDEAD;
  end

  // result monitor
  logic [15:0] exp_q[$];
  int beat = 0;
  always @(negedge clk) begin : monitor
    if (rst_n) begin
      if (rd_valid) begin
        if (exp_q.size() == 0 || rd_edges.size() == 0)
          check(0, "R4 word with no pending request", 1, 0);
        else begin
          check(rd_data == word_of(exp_q[0], beat), "R4/R11 returned word",
                int'(rd_data), int'(word_of(exp_q[0], beat)));
          check(cyc == rd_edges[0] + eff(cfg_cl) + beat, "R4 CAS latency timing",
                cyc, rd_edges[0] + eff(cfg_cl) + beat);
          check(rd_last == (beat == blen() - 1), "R5 last flag", int'(rd_last),
                int'(beat == blen() - 1));
          beat++;
          if (beat == blen()) begin
            beat = 0; void'(exp_q.pop_front()); void'(rd_edges.pop_front());
          end
        end
      end else if (beat != 0) check(0, "R5 gap inside burst", 0, 1);
    end
  end

  // front-end model of expected row commands
  bit b_open = 0;
  logic [7:0] b_row = 0;
  int exp_act = 0, exp_pre = 0;

  task automatic send(input logic [15:0] a);
    @(negedge clk);
    req_valid = 1; req_addr = a;
    while (!req_ready) @(negedge clk);
    exp_q.push_back(a);
    if (!b_open || b_row != a[15:8]) begin
      if (b_open) exp_pre++;
      exp_act++;
    end
    b_open = 1; b_row = a[15:8];
    @(posedge clk);
    @(negedge clk);
    check(!req_ready, "R10 ready after accept", int'(req_ready), 0);
    req_valid = 0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  task automatic set_cfg(input int trcd, input int cl, input int trp, input int bl, input bit r2);
    drain();
    cfg_trcd = TW'(trcd); cfg_cl = TW'(cl); cfg_trp = TW'(trp);
    cfg_bl = 2'(bl); cfg_rate2 = r2;
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (4) @(negedge clk);
    check({mem_ras_n, mem_cas_n, mem_we_n} == 3'b111, "R1 idle pins in reset",
          int'({mem_ras_n, mem_cas_n, mem_we_n}), 7);
    check(!rd_valid, "R1 no data in reset", int'(rd_valid), 0);
    rst_n = 1;
    @(negedge clk);
    check(req_ready, "R1 ready after reset", int'(req_ready), 1);
    check({mem_ras_n, mem_cas_n, mem_we_n} == 3'b111, "R9 idle after reset",
          int'({mem_ras_n, mem_cas_n, mem_we_n}), 7);

    // cold start, hit, miss
    send(16'h1234); drain();
    check(n_act == 1 && n_pre == 0, "R2 cold request opens row", n_act, 1);
    send(16'h1240); drain();
    check(n_act == 1 && n_rd == 2, "R6 hit skips row-open", n_act, 1);
    send(16'h5600); drain();
    check(n_pre == 1 && n_act == 2, "R8 miss closes then opens", n_pre, 1);
    send(16'h5601); send(16'h5603); send(16'h5607);

    // minimum timings, burst of 8
    set_cfg(1, 1, 1, 2, 1);
    send(16'h5610); send(16'h7711); send(16'h7712); send(16'h0000);
    // burst of 2 with command rate 2, long latencies, zero treated as 1
    set_cfg(4, 7, 3, 0, 1);
    send(16'h0001); send(16'h0002); send(16'hFF03); send(16'hFF04);
    set_cfg(0, 0, 0, 3, 0);
    send(16'h0105); send(16'h0106); send(16'h0207);

    // random phases
    for (int p = 0; p < 6; p++) begin
      set_cfg(1 + $urandom % 4, 1 + $urandom % 6, 1 + $urandom % 4,
              $urandom % 3, 1'($urandom % 2));
      for (int k = 0; k < 40; k++) begin
        logic [7:0] r;
        r = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 3);
        send({r, 8'($urandom)});
        if ($urandom % 2 == 0) repeat ($urandom % 4) @(negedge clk);
      end
    end
    drain();
    check(n_act == exp_act, "R6/R2 row-open count", n_act, exp_act);
    check(n_pre == exp_pre, "R8 close count", n_pre, exp_pre);
    check(exp_q.size() == 0, "R4 every request answered", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule